// File: doc/BRIEF.md
# Eight-Input Interrupt Priority Resolver

This block arbitrates eight interrupt request lines. It keeps three 8-bit registers: pending requests, levels in service, and a mask. Each cycle it picks the highest-priority pending request that is not masked. It raises its interrupt output only when that request outranks every level currently in service. Priority is circular. A 3-bit "lowest level" register fixes the order: the level just above the lowest is the highest, and the rest follow upward with wrap-around. After reset the lowest level is 7, so level 0 is the highest and level 7 the lowest.

Software can move the lowest level in two ways. It can name the level directly, or it can enable automatic rotation, in which case the level that an end-of-interrupt clears becomes the lowest. An acknowledge pulse moves the winning request from pending to in-service. A non-specific command, a specific command or the automatic mode then ends the service. Each request line is edge- or level-sensitive, chosen one bit per line.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the pending, in-service and mask registers read 0, int_out is low, and the lowest-priority level is 7.
- R2: With trig_level[i]=0 (edge, the reset default), a 0-to-1 change on irq_in[i] sets pending bit i on the next clock edge. The bit stays set after the input falls, until it is acknowledged.
- R3: With trig_level[i]=1 (level), pending bit i takes the value of irq_in[i] on every clock edge, except on the edge where level i is acknowledged, when it is cleared.
- R4: mask_we loads mask_data into the mask register. A pending level whose mask bit is 1 never wins, never raises int_out and is never acknowledged.
- R5: With the lowest level at 7, the smallest-index unmasked pending level wins. win_valid is 0 and win_lvl is 0 when no unmasked level is pending.
- R6: int_out is 1 exactly when an unmasked level is pending and its priority is strictly higher than that of every set in-service bit.
- R7: ack with a winner and aeoi_en=0 sets the winner's in-service bit and clears its pending bit on that edge. If the same edge also clears that bit by an end-of-interrupt, the set takes precedence.
- R8: eoi_ns clears the in-service bit with the highest priority under the current order.
- R9: eoi_sp clears in-service bit eoi_lvl.
- R10: With aeoi_en=1, ack clears the winner's pending bit and leaves the in-service register unchanged.
- R11: With rot_auto=1, the level cleared by eoi_ns or eoi_sp, or the level acknowledged under aeoi_en=1, becomes the lowest-priority level. eoi_ns takes precedence over eoi_sp, which takes precedence over the acknowledge.
- R12: set_low makes set_low_lvl the lowest-priority level. The level (set_low_lvl+1) mod 8 becomes the highest, and the others follow circularly. set_low takes precedence over R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Request lines, bit i is level i |
| trig_level | input | 8 | Per-line sensitivity: 1 level, 0 edge |
| mask_we | input | 1 | Load mask register |
| mask_data | input | 8 | New mask value, 1 blocks a level |
| rot_auto | input | 1 | Enable automatic rotation |
| aeoi_en | input | 1 | Automatic end-of-interrupt on acknowledge |
| eoi_ns | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_sp | input | 1 | Specific end-of-interrupt strobe |
| eoi_lvl | input | 3 | Level cleared by eoi_sp |
| set_low | input | 1 | Specific rotation strobe |
| set_low_lvl | input | 3 | Level made lowest by set_low |
| ack | input | 1 | Acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| win_valid | output | 1 | An unmasked level is pending |
| win_lvl | output | 3 | Winning level |
| irr_q | output | 8 | Pending register |
| isr_q | output | 8 | In-service register |
| imr_q | output | 8 | Mask register |

## Verification
The assertions check, on every cycle:
- a winner is always pending and unmasked, and an asserted interrupt never points at a level already in service;
- an edge-mode rise is latched unless an acknowledge intervenes;
- an acknowledge lands in the in-service register, or leaves it untouched in automatic mode;
- a lone non-specific command drops exactly one in-service bit;
- the specific rotation strobe loads the lowest level.

Whether the right bit is chosen under a rotated order, and whether automatic rotation moves the order after each kind of end-of-interrupt, shows only in the bench's scenarios. The bench compares every cycle against a reference model, over directed nesting and rotation cases and long random runs of mixed strobes and trigger modes.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  trig_level,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_data,
  input  logic          rot_auto,
  input  logic          aeoi_en,
  input  logic          eoi_ns,
  input  logic          eoi_sp,
  input  logic [LW-1:0] eoi_lvl,
  input  logic          set_low,
  input  logic [LW-1:0] set_low_lvl,
  input  logic          ack,
  output logic          int_out,
  output logic          win_valid,
  output logic [LW-1:0] win_lvl,
  output logic [N-1:0]  irr_q,
  output logic [N-1:0]  isr_q,
  output logic [N-1:0]  imr_q
);
  // N must be a power of two: ranks wrap in LW bits.
  logic [N-1:0]  irq_d;
  logic [LW-1:0] low_q;
  logic          top_v;
  logic [LW-1:0] top_lvl;
  logic [LW-1:0] scan;
  logic [N-1:0]  req;
  logic          take;
  logic [N-1:0]  set_vec, clr_vec;

  function automatic logic [LW-1:0] rank(input logic [LW-1:0] v, input logic [LW-1:0] lo);
    return v - lo - LW'(1);
  endfunction

  assign req = irr_q & ~imr_q;

  always_comb begin
    win_valid = 1'b0;
    win_lvl   = '0;
    top_v     = 1'b0;
    top_lvl   = '0;
    scan      = '0;
    for (int r = N - 1; r >= 0; r--) begin
      scan = low_q + LW'(r + 1);
      if (req[scan]) begin
        win_valid = 1'b1;
        win_lvl   = scan;
      end
      if (isr_q[scan]) begin
        top_v   = 1'b1;
        top_lvl = scan;
      end
    end
  end

  assign int_out = win_valid && (!top_v || rank(win_lvl, low_q) < rank(top_lvl, low_q));
  assign take    = ack && win_valid;
  assign set_vec = (take && !aeoi_en) ? (N'(1) << win_lvl) : '0;
  assign clr_vec = ((eoi_ns && top_v) ? (N'(1) << top_lvl) : '0) |
                   (eoi_sp ? (N'(1) << eoi_lvl) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d <= '0;
      irr_q <= '0;
      isr_q <= '0;
      imr_q <= '0;
      low_q <= LW'(N - 1);
    end else begin
      irq_d <= irq_in;
      for (int i = 0; i < N; i++)
        irr_q[i] <= trig_level[i] ? irq_in[i] : (irr_q[i] | (irq_in[i] & ~irq_d[i]));
      if (take) irr_q[win_lvl] <= 1'b0;
      isr_q <= (isr_q & ~clr_vec) | set_vec;
      if (mask_we) imr_q <= mask_data;
      if (set_low) low_q <= set_low_lvl;
      else if (rot_auto) begin
        if (eoi_ns && top_v)        low_q <= top_lvl;
        else if (eoi_sp)            low_q <= eoi_lvl;
        else if (take && aeoi_en)   low_q <= win_lvl;
      end
    end
  end

  assert_winner_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (irr_q[win_lvl] && !imr_q[win_lvl]));

  assert_int_not_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (win_valid && !isr_q[win_lvl]));

  assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> (($past(irq_in & ~irq_d & ~trig_level) & ~irr_q) == '0));

  assert_ack_to_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && !aeoi_en) |=> isr_q[$past(win_lvl)]);

  assert_auto_eoi_keeps_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi_en && !eoi_ns && !eoi_sp) |=> (isr_q == $past(isr_q)));

  assert_ns_eoi_one_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns && !eoi_sp && !ack && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  assert_set_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_low |=> (low_q == $past(set_low_lvl)));
endmodule

// File: tb/sim_irq_prio_resolver.sv
module sim_irq_prio_resolver;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, trig_level = '0, mask_data = '0;
  logic mask_we = 0, rot_auto = 0, aeoi_en = 0, eoi_ns = 0, eoi_sp = 0, set_low = 0, ack = 0;
  logic [2:0] eoi_lvl = '0, set_low_lvl = '0;
  logic int_out, win_valid;
  logic [2:0] win_lvl;
  logic [7:0] irr_q, isr_q, imr_q;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_irr = '0, m_isr = '0, m_imr = '0, m_prev = '0;
  logic [2:0] m_low = 3'd7;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_resolver u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_level),
    .mask_we(mask_we), .mask_data(mask_data), .rot_auto(rot_auto), .aeoi_en(aeoi_en),
    .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_lvl(eoi_lvl), .set_low(set_low),
    .set_low_lvl(set_low_lvl), .ack(ack), .int_out(int_out), .win_valid(win_valid),
    .win_lvl(win_lvl), .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q));

  function automatic logic [3:0] pick(input logic [7:0] v, input logic [2:0] lo);
    logic [3:0] res = 4'h0;
    for (int r = 7; r >= 0; r--) begin
      logic [2:0] l = lo + 3'(r + 1);
      if (v[l]) res = {1'b1, l};
    end
    return res;
  endfunction

  function automatic logic [2:0] rk(input logic [2:0] l, input logic [2:0] lo);
    return l - lo - 3'd1;
  endfunction

  function automatic logic exp_int();
    logic [3:0] w = pick(m_irr & ~m_imr, m_low);
    logic [3:0] t = pick(m_isr, m_low);
    return w[3] && (!t[3] || rk(w[2:0], m_low) < rk(t[2:0], m_low));
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [3:0] w = pick(m_irr & ~m_imr, m_low);
    chk(irr_q === m_irr, "R2 R3 pending", irr_q, m_irr);
    chk(isr_q === m_isr, "R7 R8 R9 R10 in-service", isr_q, m_isr);
    chk(imr_q === m_imr, "R4 mask", imr_q, m_imr);
    chk(int_out === exp_int(), "R6 R4 int_out", 8'(int_out), 8'(exp_int()));
    chk({win_valid, win_lvl} === w, "R5 R11 R12 winner", 8'({win_valid, win_lvl}), 8'(w));
  endtask

  task automatic step();
    logic [7:0] n_irr, n_isr, n_imr, clr, rise;
    logic [2:0] n_low;
    logic [3:0] w = pick(m_irr & ~m_imr, m_low);
    logic [3:0] t = pick(m_isr, m_low);
    rise = irq_in & ~m_prev;
    for (int i = 0; i < 8; i++) n_irr[i] = trig_level[i] ? irq_in[i] : (m_irr[i] | rise[i]);
    if (ack && w[3]) n_irr[w[2:0]] = 1'b0;
    clr = '0;
    if (eoi_ns && t[3]) clr[t[2:0]] = 1'b1;
    if (eoi_sp) clr[eoi_lvl] = 1'b1;
    n_isr = m_isr & ~clr;
    if (ack && w[3] && !aeoi_en) n_isr[w[2:0]] = 1'b1;
    n_imr = mask_we ? mask_data : m_imr;
    n_low = m_low;
    if (set_low) n_low = set_low_lvl;
    else if (rot_auto) begin
      if (eoi_ns && t[3]) n_low = t[2:0];
      else if (eoi_sp) n_low = eoi_lvl;
      else if (ack && w[3] && aeoi_en) n_low = w[2:0];
    end
    m_prev = irq_in;
    @(posedge clk);
    m_irr = n_irr; m_isr = n_isr; m_imr = n_imr; m_low = n_low;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irr_q == 0 && isr_q == 0 && imr_q == 0, "R1 registers cleared", irr_q | isr_q | imr_q, 8'h00);
    chk(int_out == 0, "R1 int_out low", 8'(int_out), 8'h00);

    irq_in = 8'h28; step();
    chk(win_lvl == 3'd3 && int_out, "R5 fixed order picks level 3", 8'(win_lvl), 8'h03);
    irq_in = 8'h00; ack = 1; step(); ack = 0;
    chk(isr_q == 8'h08 && irr_q == 8'h20, "R7 ack moves level 3", isr_q, 8'h08);
    chk(int_out == 0, "R6 lower level 5 held off", 8'(int_out), 8'h00);
    irq_in = 8'h01; step(); irq_in = 8'h00;
    chk(int_out == 1 && win_lvl == 0, "R6 higher level 0 nests", 8'(int_out), 8'h01);
    mask_we = 1; mask_data = 8'h01; step(); mask_we = 0;
    chk(win_lvl == 3'd5 && int_out == 0, "R4 masked level 0 ignored", 8'(win_lvl), 8'h05);
    eoi_sp = 1; eoi_lvl = 3'd3; step(); eoi_sp = 0;
    chk(isr_q == 8'h00 && int_out == 1, "R9 specific clear of level 3", isr_q, 8'h00);
    set_low = 1; set_low_lvl = 3'd0; mask_we = 1; mask_data = 8'h00; step(); set_low = 0; mask_we = 0;
    chk(win_lvl == 3'd5, "R12 lowest=0 makes 5 outrank 0", 8'(win_lvl), 8'h05);
    rot_auto = 1; ack = 1; step(); ack = 0;
    eoi_ns = 1; step(); eoi_ns = 0;
    chk(isr_q == 8'h00, "R8 non-specific clear", isr_q, 8'h00);
    irq_in = 8'h50; step(); irq_in = 8'h00;
    chk(win_lvl == 3'd6, "R11 rotation put 5 lowest so 6 wins", 8'(win_lvl), 8'h06);
    aeoi_en = 1; ack = 1; step(); ack = 0;
    chk(isr_q == 8'h00 && irr_q == 8'h11, "R10 auto clear keeps isr empty", irr_q, 8'h11);
    aeoi_en = 0; rot_auto = 0;

    for (int blk = 0; blk < 20; blk++) begin
      trig_level = 8'($urandom);
      rot_auto   = 1'($urandom);
      aeoi_en    = ($urandom % 4) == 0;
      for (int c = 0; c < 200; c++) begin
        irq_in      = irq_in ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
        mask_we     = ($urandom % 16) == 0;
        mask_data   = 8'($urandom) & 8'($urandom);
        ack         = ($urandom % 6) == 0;
        eoi_ns      = ($urandom % 10) == 0;
        eoi_sp      = ($urandom % 12) == 0;
        eoi_lvl     = 3'($urandom);
        set_low     = ($urandom % 25) == 0;
        set_low_lvl = 3'($urandom);
        step();
      end
    end
    {mask_we, ack, eoi_ns, eoi_sp, set_low} = '0;
    step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule